// File: doc/BRIEF.md
# Processor Effective Address Generator

This block turns an addressing-mode selector and the operand bytes of a classic 8-bit processor instruction into the 16-bit effective address that the instruction uses. It handles the two index registers and the page-zero wraparound, as well as the pointer-based modes, which need two bytes read back from memory. It also reports the extra clock cycle that a page crossing costs. For relative branches it produces the target address and the total extra-cycle count of the branch.

A request is a one-cycle `start` pulse with the mode and operands on the inputs. Direct modes finish on the next clock edge. The pointer modes issue two byte reads, low byte first, on a request/acknowledge read port. They finish on the edge after the second acknowledge. Each result is marked by a single-cycle `done` pulse. Instruction decode and the data access itself are left to neighbouring logic.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and right after it, `done` and `rd_req` are low.
- R2: Modes 0 (page zero), 1 (page zero + X) and 2 (page zero + Y) give `{8'h00, (operand_low + index) mod 256}`, with zero extra cycles. `done` is high on the first clock edge after the accepted `start`.
- R3: Modes 3 (absolute), 4 (absolute + X) and 5 (absolute + Y) give `{operand_high, operand_low} + index` modulo 0x10000. Mode 3 uses an index of zero.
- R4: In modes 4, 5 and 7, `page_cross` is 1 exactly when the low byte of the final address is below the index value, and `extra_cyc` equals `page_cross`.
- R5: Mode 6 (X-pre-indexed pointer) reads the pointer low byte from page-zero address `(operand_low + X) mod 256` and the high byte from the following page-zero address, also modulo 256. The pointer is the result.
- R6: Mode 7 (Y-post-indexed pointer) reads the pointer from page-zero addresses `operand_low` and `(operand_low + 1) mod 256`. The result is that pointer plus Y, modulo 0x10000.
- R7: Mode 8 (indirect jump) reads the pointer low byte at `{operand_high, operand_low}`. It reads the high byte at `{operand_high, (operand_low + 1) mod 256}`, so a low byte of 0xFF fetches from the start of the same page.
- R8: Mode 9 (relative branch) gives `pc + sign_extend(operand_low)`. `page_cross` is 1 when the high byte of the target differs from the high byte of `pc`. `extra_cyc` is 0 when `br_taken` is 0, 1 when the branch is taken in the same page, and 2 when it is taken across a page.
- R9: Only one read is outstanding at a time. `rd_req` and `rd_addr` are held unchanged until `rd_ack`. The low byte is read before the high byte. With immediate acknowledges, `done` is high on the third edge after `start`.
- R10: `done` lasts exactly one cycle, and a `start` arriving while pointer reads are in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 4 | Addressing mode selector (0..9) |
| opnd_lo | input | 8 | First operand byte (also the branch offset) |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Program counter after the branch instruction |
| br_taken | input | 1 | Branch condition is true |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 8 | Read response byte |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Page crossed by indexing or branch |
| extra_cyc | output | 2 | Extra cycles owed (0, 1 or 2) |
| done | output | 1 | One-cycle result strobe |

## Verification
The page-zero modes are tried with sums that stay inside the page and with sums that wrap past 0xFF. This separates a wrap at 8 bits from a plain 16-bit add. The indexed absolute modes use one sum that stays in its page, one that crosses a page, and one that wraps past 0xFFFF, which shows whether the crossing rule compares low bytes. Pointer modes are placed at 0xFE/0xFF so that the second read must wrap within its page. The indirect jump is also run with an ordinary low byte so the quirk is not applied everywhere. Branches are run forward and backward, taken and not taken, inside and across pages, and a stalled read with a competing `start` shows that addresses are held and a busy request is dropped.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7,
    AM_JIND = 4'd8,
    AM_REL  = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LO   = 2'd1,
    PS_HI   = 2'd2
  } pstate_e;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base_i,
  input  logic [DW-1:0]   idx_i,
  output logic [2*DW-1:0] sum_o,
  output logic            cross_o
);
  localparam int AW = 2 * DW;

  always_comb begin
    sum_o   = base_i + {{DW{1'b0}}, idx_i};
    // carry out of the low byte shows up as a wrapped low byte below the index
    cross_o = (sum_o[DW-1:0] < idx_i);
  end
endmodule

// File: rtl/ea_branch.sv
module ea_branch #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] pc_i,
  input  logic [DW-1:0]   off_i,
  output logic [2*DW-1:0] tgt_o,
  output logic            cross_o
);
  localparam int AW = 2 * DW;

  always_comb begin
    tgt_o   = pc_i + {{DW{off_i[DW-1]}}, off_i};
    cross_o = (tgt_o[AW-1:DW] != pc_i[AW-1:DW]);
  end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq
  import ea_gen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2*DW-1:0] lo_addr_i,
  input  logic [2*DW-1:0] hi_addr_i,
  output logic            rd_req_o,
  output logic [2*DW-1:0] rd_addr_o,
  input  logic            rd_ack_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] ptr_o
);
  localparam int AW = 2 * DW;

  pstate_e       st_q, st_n;
  logic [AW-1:0] alo_q, ahi_q;
  logic [DW-1:0] blo_q;
  logic          cap_addr, cap_lo;

  always_comb begin
    st_n     = st_q;
    cap_addr = 1'b0;
    cap_lo   = 1'b0;
    case (st_q)
      PS_IDLE: if (start_i) begin
        st_n     = PS_LO;
        cap_addr = 1'b1;
      end
      PS_LO: if (rd_ack_i) begin
        st_n   = PS_HI;
        cap_lo = 1'b1;
      end
      PS_HI: if (rd_ack_i) st_n = PS_IDLE;
      default: st_n = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      alo_q <= '0;
      ahi_q <= '0;
      blo_q <= '0;
    end else begin
      st_q <= st_n;
      if (cap_addr) begin
        alo_q <= lo_addr_i;
        ahi_q <= hi_addr_i;
      end
      if (cap_lo) blo_q <= rd_data_i;
    end
  end

  assign rd_req_o  = (st_q != PS_IDLE);
  assign rd_addr_o = (st_q == PS_HI) ? ahi_q : alo_q;
  assign busy_o    = (st_q != PS_IDLE);
  assign done_o    = (st_q == PS_HI) && rd_ack_i;
  assign ptr_o     = {rd_data_i, blo_q};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [DW-1:0]   opnd_lo,
  input  logic [DW-1:0]   opnd_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [2*DW-1:0] pc,
  input  logic            br_taken,
  output logic            rd_req,
  output logic [2*DW-1:0] rd_addr,
  input  logic            rd_ack,
  input  logic [DW-1:0]   rd_data,
  output logic [2*DW-1:0] ea,
  output logic            page_cross,
  output logic [1:0]      extra_cyc,
  output logic            done
);
  localparam int            AW   = 2 * DW;
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] ZPG  = '0;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  amode_e        mode_in, mode_q, cur_mode;
  logic [DW-1:0] y_q;
  logic          busy, ptr_done, accept, is_ptr, start_ptr, load_direct, load;
  logic [AW-1:0] ptr_val, p_lo_addr, p_hi_addr;
  logic [DW-1:0] zp_x, zp_y;

  assign mode_in     = amode_e'(mode);
  assign accept      = start && !busy;
  assign is_ptr      = (mode_in == AM_INDX) || (mode_in == AM_INDY) || (mode_in == AM_JIND);
  assign start_ptr   = accept && is_ptr;
  assign load_direct = accept && !is_ptr;
  assign zp_x        = opnd_lo + idx_x;
  assign zp_y        = opnd_lo + idx_y;

  // pointer byte locations; the high byte never carries into the next page
  always_comb begin
    case (mode_in)
      AM_INDX: begin
        p_lo_addr = {ZPG, zp_x};
        p_hi_addr = {ZPG, zp_x + ONE};
      end
      AM_INDY: begin
        p_lo_addr = {ZPG, opnd_lo};
        p_hi_addr = {ZPG, opnd_lo + ONE};
      end
      default: begin
        p_lo_addr = {opnd_hi, opnd_lo};
        p_hi_addr = {opnd_hi, opnd_lo + ONE};
      end
    endcase
  end

  ea_ptr_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start_i   (start_ptr),
    .lo_addr_i (p_lo_addr),
    .hi_addr_i (p_hi_addr),
    .rd_req_o  (rd_req),
    .rd_addr_o (rd_addr),
    .rd_ack_i  (rd_ack),
    .rd_data_i (rd_data),
    .busy_o    (busy),
    .done_o    (ptr_done),
    .ptr_o     (ptr_val)
  );

  // one shared adder serves absolute-indexed and post-indexed pointer modes
  logic [AW-1:0] add_base, add_sum, br_tgt;
  logic [DW-1:0] add_idx;
  logic          add_cross, br_cross;

  assign cur_mode = ptr_done ? mode_q : mode_in;

  always_comb begin
    add_base = {opnd_hi, opnd_lo};
    add_idx  = '0;
    case (cur_mode)
      AM_ABSX: add_idx = idx_x;
      AM_ABSY: add_idx = idx_y;
      AM_INDY: begin
        add_base = ptr_val;
        add_idx  = y_q;
      end
      default: ;
    endcase
  end

  ea_index_add #(.DW(DW)) u_add (
    .base_i  (add_base),
    .idx_i   (add_idx),
    .sum_o   (add_sum),
    .cross_o (add_cross)
  );

  ea_branch #(.DW(DW)) u_br (
    .pc_i    (pc),
    .off_i   (opnd_lo),
    .tgt_o   (br_tgt),
    .cross_o (br_cross)
  );

  logic [AW-1:0] ea_n;
  logic          cross_n;
  logic [1:0]    extra_n;

  always_comb begin
    ea_n    = '0;
    cross_n = 1'b0;
    extra_n = 2'd0;
    case (cur_mode)
      AM_ZP:  ea_n = {ZPG, opnd_lo};
      AM_ZPX: ea_n = {ZPG, zp_x};
      AM_ZPY: ea_n = {ZPG, zp_y};
      AM_ABS, AM_ABSX, AM_ABSY, AM_INDY: begin
        ea_n    = add_sum;
        cross_n = add_cross;
        extra_n = {1'b0, add_cross};
      end
      AM_INDX, AM_JIND: ea_n = ptr_val;
      AM_REL: begin
        ea_n    = br_tgt;
        cross_n = br_cross;
        extra_n = br_taken ? (br_cross ? 2'd2 : 2'd1) : 2'd0;
      end
      default: ;
    endcase
  end

  assign load = load_direct || ptr_done;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q     <= AM_ZP;
      y_q        <= '0;
      ea         <= '0;
      page_cross <= 1'b0;
      extra_cyc  <= 2'd0;
      done       <= 1'b0;
    end else begin
      if (accept) begin
        mode_q <= mode_in;
        y_q    <= idx_y;
      end
      if (load) begin
        ea         <= ea_n;
        page_cross <= cross_n;
        extra_cyc  <= extra_n;
      end
      done <= load;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_ack,
  input logic [2*DW-1:0] rd_addr,
  input logic            done,
  input logic            page_cross,
  input logic [1:0]      extra_cyc,
  input logic [2*DW-1:0] ea,
  input logic [3:0]      mode_q
);
  localparam int AW = 2 * DW;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_extra_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> extra_cyc != 2'd3);

  p_ptr_zpage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && (mode_q == 4'd6 || mode_q == 4'd7) |-> rd_addr[AW-1:DW] == '0);

  p_zp_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q <= 4'd2) |-> ea[AW-1:DW] == '0 && extra_cyc == 2'd0);

  p_idx_extra_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == 4'd4 || mode_q == 4'd5 || mode_q == 4'd7)
    |-> extra_cyc == {1'b0, page_cross});
endmodule

bind ea_gen ea_gen_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_ack     (rd_ack),
  .rd_addr    (rd_addr),
  .done       (done),
  .page_cross (page_cross),
  .extra_cyc  (extra_cyc),
  .ea         (ea),
  .mode_q     (mode_q)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc = '0;
  logic        br_taken = 1'b0;
  logic        rd_req, rd_ack, page_cross, done;
  logic [15:0] rd_addr, ea;
  logic [7:0]  rd_data;
  logic [1:0]  extra_cyc;
  logic        stall = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rlog [0:7];
  int          rcnt = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign rd_ack  = rd_req & ~stall;
  assign rd_data = mb(rd_addr);

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .pc(pc), .br_taken(br_taken), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .ea(ea), .page_cross(page_cross),
    .extra_cyc(extra_cyc), .done(done)
  );

  // records accepted reads for the ordering checks
  always @(negedge clk) begin
    if (rd_req && rd_ack && rcnt < 8) begin
      rlog[rcnt] = rd_addr;
      rcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                        input logic tk, input logic [15:0] exp_ea, input logic exp_pc,
                        input logic [1:0] exp_ex, input int exp_lat, input string req);
    int lat;
    @(negedge clk);
    rcnt = 0;
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p; br_taken = tk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(ea == exp_ea, {req, " address"}, 32'(ea), 32'(exp_ea));
    chk(page_cross == exp_pc, {req, " page_cross"}, 32'(page_cross), 32'(exp_pc));
    chk(extra_cyc == exp_ex, {req, " extra_cyc"}, 32'(extra_cyc), 32'(exp_ex));
    chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    chk(rd_req == 1'b0, "R1 rd_req in reset", 32'(rd_req), 32'd0);
  endtask

  task automatic t_zpage;
    run_op(4'd0, 8'h42, 8'h99, 8'h10, 8'h20, 16'h0, 1'b0, 16'h0042, 1'b0, 2'd0, 1, "R2 zp");
    run_op(4'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0, 16'h0010, 1'b0, 2'd0, 1, "R2 zpx wrap");
    run_op(4'd2, 8'h80, 8'h12, 8'h00, 8'h7F, 16'h0, 1'b0, 16'h00FF, 1'b0, 2'd0, 1, "R2 zpy");
  endtask

  task automatic t_absolute;
    run_op(4'd3, 8'h34, 8'h12, 8'hFF, 8'hFF, 16'h0, 1'b0, 16'h1234, 1'b0, 2'd0, 1, "R3 abs");
    run_op(4'd4, 8'hF0, 8'h12, 8'h05, 8'h00, 16'h0, 1'b0, 16'h12F5, 1'b0, 2'd0, 1, "R3 absx same page");
    run_op(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0, 16'h1310, 1'b1, 2'd1, 1, "R4 absx cross");
    run_op(4'd5, 8'hFF, 8'hFF, 8'h00, 8'h02, 16'h0, 1'b0, 16'h0001, 1'b1, 2'd1, 1, "R4 absy wrap 64K");
  endtask

  task automatic t_pre_index;
    logic [15:0] e;
    e = {mb(16'h0000), mb(16'h00FF)};
    run_op(4'd6, 8'hFE, 8'h55, 8'h01, 8'h00, 16'h0, 1'b0, e, 1'b0, 2'd0, 3, "R5 pre-index");
    chk(rlog[0] == 16'h00FF, "R5 low byte addr", 32'(rlog[0]), 32'h00FF);
    chk(rlog[1] == 16'h0000, "R9 high byte addr wraps", 32'(rlog[1]), 32'h0000);
  endtask

  task automatic t_post_index;
    logic [15:0] p, e;
    logic        c;
    p = {mb(16'h0000), mb(16'h00FF)};
    e = p + 16'h00C0;
    c = (e[7:0] < 8'hC0);
    run_op(4'd7, 8'hFF, 8'h33, 8'h00, 8'hC0, 16'h0, 1'b0, e, c, {1'b0, c}, 3, "R6 post-index");
    chk(rlog[1] == 16'h0000, "R6 high byte in page zero", 32'(rlog[1]), 32'h0000);
    p = {mb(16'h0011), mb(16'h0010)};
    e = p + 16'h0003;
    c = (e[7:0] < 8'h03);
    run_op(4'd7, 8'h10, 8'h00, 8'h00, 8'h03, 16'h0, 1'b0, e, c, {1'b0, c}, 3, "R4 post-index cross rule");
  endtask

  task automatic t_jump_ind;
    logic [15:0] e;
    e = {mb(16'h3000), mb(16'h30FF)};
    run_op(4'd8, 8'hFF, 8'h30, 8'h00, 8'h00, 16'h0, 1'b0, e, 1'b0, 2'd0, 3, "R7 page quirk");
    chk(rlog[1] == 16'h3000, "R7 high read addr", 32'(rlog[1]), 32'h3000);
    e = {mb(16'h3011), mb(16'h3010)};
    run_op(4'd8, 8'h10, 8'h30, 8'h00, 8'h00, 16'h0, 1'b0, e, 1'b0, 2'd0, 3, "R7 normal");
    chk(rlog[0] == 16'h3010 && rlog[1] == 16'h3011, "R9 read order", 32'({rlog[0], rlog[1]}), 32'h30103011);
  endtask

  task automatic t_branch;
    run_op(4'd9, 8'h05, 8'h00, 8'h00, 8'h00, 16'h10F0, 1'b1, 16'h10F5, 1'b0, 2'd1, 1, "R8 taken same page");
    run_op(4'd9, 8'h20, 8'h00, 8'h00, 8'h00, 16'h10F0, 1'b1, 16'h1110, 1'b1, 2'd2, 1, "R8 taken cross");
    run_op(4'd9, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h1005, 1'b1, 16'h0FF5, 1'b1, 2'd2, 1, "R8 backward cross");
    run_op(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h10F0, 1'b0, 16'h1070, 1'b0, 2'd0, 1, "R8 not taken");
    run_op(4'd9, 8'h20, 8'h00, 8'h00, 8'h00, 16'h10F0, 1'b0, 16'h1110, 1'b1, 2'd0, 1, "R8 not taken cross");
  endtask

  task automatic t_stall_busy;
    int lat;
    logic [15:0] e;
    e = {mb(16'h0041), mb(16'h0040)};
    @(negedge clk);
    rcnt = 0;
    stall = 1'b1;
    mode = 4'd6; opnd_lo = 8'h30; idx_x = 8'h10; start = 1'b1;
    @(negedge clk);
    // competing request while busy: must be dropped
    mode = 4'd0; opnd_lo = 8'h77; idx_x = 8'h00; start = 1'b1;
    chk(rd_req && rd_addr == 16'h0040, "R9 request raised", 32'(rd_addr), 32'h0040);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    lat++;
    chk(rd_req && rd_addr == 16'h0040, "R9 address held in stall", 32'(rd_addr), 32'h0040);
    @(negedge clk);
    lat++;
    stall = 1'b0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(ea == e, "R10 busy start ignored", 32'(ea), 32'(e));
    chk(lat == 5, "R9 stalled latency", 32'(lat), 32'd5);
    @(negedge clk);
    chk(done == 1'b0 && rd_req == 1'b0, "R10 no second result", 32'({done, rd_req}), 32'd0);
  endtask

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_zpage();
    t_absolute();
    t_pre_index();
    t_post_index();
    t_jump_ind();
    t_branch();
    t_stall_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule